// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a 7-bit-address slave on a two-wire serial bus. It holds four 8-bit control registers whose outputs drive the rest of the design. The registers sit at scattered subaddresses. The first two also appear at separate read-only mirror addresses. The block runs on the system clock. It sees the bus clock and data lines as signals that are already synchronized. It pulls the data line low through a single open-drain enable.

A write transfer sends the device byte, then one subaddress byte, then any number of data bytes. A read transfer returns bytes from the current pointer. The usual way to set that pointer is a write of one subaddress byte, followed by a repeated start in the read direction. After each data byte, the pointer moves to the next address that exists in the map. It never stops on an unused address, and it stays at the top of the map. The slave abandons a transfer and returns to idle on any start or stop condition.

Top module: `i2c_ctrl_regs`

## Requirements
- R1: The slave acknowledges a first byte whose upper seven bits are 1,0,0,0,0,`strap_a2_i`,`strap_a1_i`. Bit 0 of that byte is 1 for a read and 0 for a write. On any other value the slave leaves SDA released on the ninth clock and ignores the bus until the next start.
- R2: Bits travel MSB first. An acknowledge is SDA held low by the slave while SCL is high in the ninth clock of a byte.
- R3: In a write, a valid second byte is acknowledged and becomes the pointer. Each following data byte is acknowledged and stored at the pointer. The store happens on the SCL falling edge that ends the eighth bit.
- R4: After reset all four control registers read 0x00, and the pointer is 0x05.
- R5: The valid subaddresses in ascending order are 0x05, 0x06, 0x08, 0x09, 0x11 and 0x22. After each data byte, in either direction, the pointer moves to the next address in that list.
- R6: A write to 0x05 or 0x06 is acknowledged and changes no register.
- R7: A second byte that is not a valid subaddress gets no acknowledge. The slave goes idle, and later bytes up to the next start get neither an acknowledge nor a store.
- R8: A read returns register A from 0x05 or 0x08, register B from 0x06 or 0x09, register C from 0x11 and register D from 0x22. Register A drives `ctl_a_o`, B drives `ctl_b_o`, C drives `ctl_c_o` and D drives `ctl_d_o`.
- R9: A read that passes 0x22 returns register D again for every further byte the master acknowledges. A master no-acknowledge ends the read and releases SDA.
- R10: A start or stop anywhere in a transfer abandons it: a partial byte is not stored, and a stop releases SDA. A start, including a repeated start, always begins a new device-address byte.
- R11: Write data bytes that run past 0x22 all land in register D, so the last one wins.
- R12: The slave drives SDA only during acknowledge bits and read-data bits. It pulls SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level |
| strap_a2_i | input | 1 | Device address bit 2 strap |
| strap_a1_i | input | 1 | Device address bit 1 strap |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| ctl_a_o | output | 8 | Control register A |
| ctl_b_o | output | 8 | Control register B |
| ctl_c_o | output | 8 | Control register C |
| ctl_d_o | output | 8 | Control register D |

## Verification
A wrong pointer shows up within a single byte: a read returns a value from the wrong register, or a write changes the wrong output. The walk through the map is therefore checked byte by byte, with a different value in each register. A protocol state that is out of step shows up at the next ninth clock, as a missing or spurious acknowledge. It can also appear as the slave driving SDA during a master bit, which the bench samples on every bit. An abort that fails to clear state shows up on the first transfer after the abort: a stale partial byte would be stored, or the fresh address would be refused.

// File: rtl/i2c_ctrl_pkg.sv
package i2c_ctrl_pkg;
  localparam int DATA_W = 8;
  localparam int N_WREG = 4;
  localparam int N_MIRROR = 2;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [4:0] DEV_HI = 5'b10000;
  // writable addresses, index 0 is register A
  localparam logic [N_WREG*DATA_W-1:0] WR_ADDRS = {8'h22, 8'h11, 8'h09, 8'h08};
  // mirror i reads back register i
  localparam logic [N_MIRROR*DATA_W-1:0] MIR_ADDRS = {8'h06, 8'h05};
  localparam logic [DATA_W-1:0] PTR_RST = 8'h05;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } slv_st_e;
endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // data edges while the clock stays high
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_reg_map.sv
module i2c_reg_map
  import i2c_ctrl_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [DATA_W-1:0]             chk_addr_i,
  output logic                          chk_ok_o,
  input  logic [DATA_W-1:0]             ptr_i,
  output logic [DATA_W-1:0]             ptr_next_o,
  output logic [DATA_W-1:0]             rd_data_o,
  input  logic                          wr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  output logic [N_WREG-1:0]             wr_hit_o,
  output logic [N_WREG-1:0][DATA_W-1:0] ctl_o
);
  logic [N_WREG-1:0][DATA_W-1:0] regs_q;

  always_comb begin
    chk_ok_o = 1'b0;
    for (int i = 0; i < N_WREG; i++)
      if (chk_addr_i == WR_ADDRS[i*DATA_W +: DATA_W]) chk_ok_o = 1'b1;
    for (int j = 0; j < N_MIRROR; j++)
      if (chk_addr_i == MIR_ADDRS[j*DATA_W +: DATA_W]) chk_ok_o = 1'b1;
  end

  // smallest valid address above the pointer, else hold
  always_comb begin
    logic found;
    found = 1'b0;
    ptr_next_o = ptr_i;
    for (int i = 0; i < N_WREG; i++) begin
      if (WR_ADDRS[i*DATA_W +: DATA_W] > ptr_i &&
          (!found || WR_ADDRS[i*DATA_W +: DATA_W] < ptr_next_o)) begin
        ptr_next_o = WR_ADDRS[i*DATA_W +: DATA_W];
        found = 1'b1;
      end
    end
    for (int j = 0; j < N_MIRROR; j++) begin
      if (MIR_ADDRS[j*DATA_W +: DATA_W] > ptr_i &&
          (!found || MIR_ADDRS[j*DATA_W +: DATA_W] < ptr_next_o)) begin
        ptr_next_o = MIR_ADDRS[j*DATA_W +: DATA_W];
        found = 1'b1;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N_WREG; i++)
      if (ptr_i == WR_ADDRS[i*DATA_W +: DATA_W]) rd_data_o = regs_q[i];
    for (int j = 0; j < N_MIRROR; j++)
      if (ptr_i == MIR_ADDRS[j*DATA_W +: DATA_W]) rd_data_o = regs_q[j];
  end

  generate
    for (genvar g = 0; g < N_WREG; g++) begin : g_hit
      assign wr_hit_o[g] = wr_i && (ptr_i == WR_ADDRS[g*DATA_W +: DATA_W]);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else begin
      for (int i = 0; i < N_WREG; i++)
        if (wr_hit_o[i]) regs_q[i] <= wr_data_i;
    end
  end

  assign ctl_o = regs_q;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic              strap_a2_i,
  input  logic              strap_a1_i,
  output logic [DATA_W-1:0] shreg_o,
  input  logic              sub_ok_i,
  output logic [DATA_W-1:0] ptr_o,
  input  logic [DATA_W-1:0] ptr_next_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_o,
  output logic              sda_pull_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

  slv_st_e           state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] ptr_q;
  logic              rw_q;
  logic              mack_q;
  logic              pull_q;
  logic              byte_end;
  logic              dev_hit;

  assign byte_end = scl_fall_i && (cnt_q == CNT_FULL);
  assign dev_hit  = (shreg_q[7:1] == {DEV_HI, strap_a2_i, strap_a1_i});
  assign wr_o     = (state_q == ST_WR) && byte_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      ptr_q   <= PTR_RST;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      pull_q  <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      pull_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_SUB, ST_WR: begin
          if (scl_rise_i && cnt_q != CNT_FULL) begin
            shreg_q <= {shreg_q[DATA_W-2:0], sda_i};
            cnt_q   <= cnt_q + 1'b1;
          end
          if (byte_end) begin
            cnt_q <= '0;
            if (state_q == ST_ADDR) begin
              if (dev_hit) begin
                rw_q    <= shreg_q[0];
                pull_q  <= 1'b1;
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_SUB) begin
              if (sub_ok_i) begin
                ptr_q   <= shreg_q;
                pull_q  <= 1'b1;
                state_q <= ST_SUB_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              ptr_q   <= ptr_next_i;
              pull_q  <= 1'b1;
              state_q <= ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            if (rw_q) begin
              shreg_q <= rd_data_i;
              pull_q  <= ~rd_data_i[DATA_W-1];
              ptr_q   <= ptr_next_i;
              cnt_q   <= '0;
              state_q <= ST_RD;
            end else begin
              pull_q  <= 1'b0;
              state_q <= ST_SUB;
            end
          end
        end
        ST_SUB_ACK, ST_WR_ACK: begin
          if (scl_fall_i) begin
            pull_q  <= 1'b0;
            state_q <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise_i) cnt_q <= cnt_q + 1'b1;
          if (scl_fall_i) begin
            if (cnt_q == CNT_FULL) begin
              pull_q  <= 1'b0;
              state_q <= ST_RD_ACK;
            end else begin
              shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
              pull_q  <= ~shreg_q[DATA_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) mack_q <= ~sda_i;
          if (scl_fall_i) begin
            if (mack_q) begin
              shreg_q <= rd_data_i;
              pull_q  <= ~rd_data_i[DATA_W-1];
              ptr_q   <= ptr_next_i;
              cnt_q   <= '0;
              state_q <= ST_RD;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign shreg_o    = shreg_q;
  assign ptr_o      = ptr_q;
  assign sda_pull_o = pull_q;
endmodule

// File: rtl/i2c_ctrl_regs.sv
module i2c_ctrl_regs
  import i2c_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       strap_a2_i,
  input  logic       strap_a1_i,
  output logic       sda_pull_o,
  output logic [7:0] ctl_a_o,
  output logic [7:0] ctl_b_o,
  output logic [7:0] ctl_c_o,
  output logic [7:0] ctl_d_o
);
  logic scl_rise, scl_fall, bus_start, bus_stop;
  logic [DATA_W-1:0] shreg, ptr, ptr_next, rd_data;
  logic sub_ok, wr;
  logic [N_WREG-1:0] wr_hit;
  logic [N_WREG-1:0][DATA_W-1:0] ctl;

  i2c_bus_events i_events (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  i2c_slave_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .sda_i      (sda_i),
    .strap_a2_i (strap_a2_i),
    .strap_a1_i (strap_a1_i),
    .shreg_o    (shreg),
    .sub_ok_i   (sub_ok),
    .ptr_o      (ptr),
    .ptr_next_i (ptr_next),
    .rd_data_i  (rd_data),
    .wr_o       (wr),
    .sda_pull_o (sda_pull_o)
  );

  i2c_reg_map i_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chk_addr_i (shreg),
    .chk_ok_o   (sub_ok),
    .ptr_i      (ptr),
    .ptr_next_o (ptr_next),
    .rd_data_o  (rd_data),
    .wr_i       (wr),
    .wr_data_i  (shreg),
    .wr_hit_o   (wr_hit),
    .ctl_o      (ctl)
  );

  assign ctl_a_o = ctl[0];
  assign ctl_b_o = ctl[1];
  assign ctl_c_o = ctl[2];
  assign ctl_d_o = ctl[3];
endmodule

// File: rtl/i2c_ctrl_regs_chk.sv
module i2c_ctrl_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_i,
  input logic        sda_i,
  input logic        sda_pull_i,
  input logic [31:0] ctl_all_i,
  input logic [3:0]  wr_hit_i
);
  logic scl_d, sda_d, stop_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
    end
  end

  assign stop_seen = scl_i && scl_d && sda_i && !sda_d;

  AST_PULL_STARTS_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_i) |-> !scl_i); // R12

  AST_RELEASED_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_seen |=> !sda_pull_i); // R10

  AST_STORE_ON_SCL_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_all_i != $past(ctl_all_i)) |-> (!$past(scl_i) && $past(scl_i, 2))); // R3

  AST_SINGLE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_hit_i)); // R5

  AST_STORE_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_all_i != $past(ctl_all_i)) |-> ($past(wr_hit_i) != 4'b0)); // R6
endmodule

bind i2c_ctrl_regs i2c_ctrl_regs_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .sda_i      (sda_i),
  .sda_pull_i (sda_pull_o),
  .ctl_all_i  ({ctl_d_o, ctl_c_o, ctl_b_o, ctl_a_o}),
  .wr_hit_i   (wr_hit)
);

// File: tb/test_i2c_ctrl_regs.sv
module test_i2c_ctrl_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic sda_bus;
  logic [7:0] ctl_a, ctl_b, ctl_c, ctl_d;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    int    val;
    string tag;
    string what;
  } exp_t;
  exp_t exp_q[$];
  event obs_ev;
  int   obs_val;

  localparam logic [7:0] DEV_W = 8'h84;  // straps a2=1 a1=0
  localparam logic [7:0] DEV_R = 8'h85;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  i2c_ctrl_regs i_i2c_ctrl_regs (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_bus),
    .strap_a2_i (1'b1),
    .strap_a1_i (1'b0),
    .sda_pull_o (sda_pull),
    .ctl_a_o    (ctl_a),
    .ctl_b_o    (ctl_b),
    .ctl_c_o    (ctl_c),
    .ctl_d_o    (ctl_d)
  );

  // monitor: compares each observation with the oldest expectation
  initial forever begin
    exp_t e;
    @(obs_ev);
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL scoreboard: unexpected observation %0h", obs_val);
    end else begin
      e = exp_q.pop_front();
      if (obs_val != e.val) begin
        n_fail++;
        $display("FAIL %s %s: actual %0h expected %0h", e.tag, e.what, obs_val, e.val);
      end
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(int v, string tag, string what);
    exp_q.push_back('{val: v, tag: tag, what: what});
  endtask

  task automatic observe(int v);
    obs_val = v;
    -> obs_ev;
    @(negedge clk);
  endtask

  task automatic check_out(int act, int exp, string tag, string what);
    expect_item(exp, tag, what);
    observe(act);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_n(2);
    scl = 1'b1;   wait_n(2);
    sda_m = 1'b0; wait_n(2);
    scl = 1'b0;   wait_n(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_n(2);
    scl = 1'b1;   wait_n(2);
    sda_m = 1'b1; wait_n(4);
  endtask

  task automatic put_bit(bit b, inout bit drove);
    sda_m = b; wait_n(2);
    scl = 1'b1; wait_n(2);
    if (sda_pull) drove = 1'b1;
    wait_n(2);
    scl = 1'b0; wait_n(2);
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; wait_n(2);
    scl = 1'b1; wait_n(2);
    b = sda_bus;
    wait_n(2);
    scl = 1'b0; wait_n(2);
  endtask

  // master sends a byte; exp_ack 0 = slave acknowledges
  task automatic send_byte(logic [7:0] b, int exp_ack, string tag);
    bit drove = 1'b0;
    bit a;
    expect_item(0, "R12", "slave drove SDA during master bit");
    expect_item(exp_ack, tag, "ninth-clock SDA");
    for (int i = 7; i >= 0; i--) put_bit(b[i], drove);
    observe(int'(drove));
    get_bit(a);
    observe(int'(a));
  endtask

  task automatic recv_byte(logic [7:0] exp_v, bit mack, string tag);
    logic [7:0] v = '0;
    bit b;
    bit dummy = 1'b0;
    expect_item(int'(exp_v), tag, "read byte");
    for (int i = 0; i < 8; i++) begin
      get_bit(b);
      v = {v[6:0], b};
    end
    observe(int'(v));
    put_bit(~mack, dummy);
  endtask

  task automatic partial_bits(int n, logic [7:0] b);
    bit d = 1'b0;
    for (int i = 7; i > 7 - n; i--) put_bit(b[i], d);
  endtask

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(4);

    // R4 reset values
    check_out(ctl_a, 0, "R4", "ctl_a after reset");
    check_out(ctl_b, 0, "R4", "ctl_b after reset");
    check_out(ctl_c, 0, "R4", "ctl_c after reset");
    check_out(ctl_d, 0, "R4", "ctl_d after reset");

    // R4: read at reset pointer 0x05
    bus_start();
    send_byte(DEV_R, 0, "R1");
    recv_byte(8'h00, 1'b0, "R4");
    bus_stop();

    // R1 wrong device address (a1 bit set)
    bus_start();
    send_byte(8'h86, 1, "R1");
    send_byte(8'h08, 1, "R1");
    bus_stop();
    check_out(ctl_a, 0, "R1", "ctl_a after foreign address");

    // R3 R5 R11 burst write from 0x08
    bus_start();
    send_byte(DEV_W, 0, "R1");
    send_byte(8'h08, 0, "R3");
    send_byte(8'hA5, 0, "R3");
    send_byte(8'h3C, 0, "R5");
    send_byte(8'h71, 0, "R5");
    send_byte(8'hE2, 0, "R5");
    send_byte(8'h99, 0, "R11");
    bus_stop();
    check_out(ctl_a, 'hA5, "R2", "ctl_a MSB-first store");
    check_out(ctl_b, 'h3C, "R5", "ctl_b via autoincrement");
    check_out(ctl_c, 'h71, "R5", "ctl_c skips gap to 0x11");
    check_out(ctl_d, 'h99, "R11", "ctl_d last write past top");

    // R6 writes to mirrors ignored, autoincrement 0x06 -> 0x08
    bus_start();
    send_byte(DEV_W, 0, "R1");
    send_byte(8'h05, 0, "R3");
    send_byte(8'h11, 0, "R6");
    send_byte(8'h22, 0, "R6");
    send_byte(8'h33, 0, "R5");
    bus_stop();
    check_out(ctl_a, 'h33, "R5", "ctl_a after 0x06 -> 0x08 step");
    check_out(ctl_b, 'h3C, "R6", "ctl_b untouched by mirror write");

    // R7 invalid subaddress
    bus_start();
    send_byte(DEV_W, 0, "R1");
    send_byte(8'h07, 1, "R7");
    send_byte(8'h55, 1, "R7");
    bus_stop();
    check_out(ctl_a, 'h33, "R7", "ctl_a after invalid subaddress");
    check_out(ctl_b, 'h3C, "R7", "ctl_b after invalid subaddress");

    // R8 R9 R10 repeated-start read walk
    bus_start();
    send_byte(DEV_W, 0, "R1");
    send_byte(8'h05, 0, "R3");
    bus_start();
    send_byte(DEV_R, 0, "R10");
    recv_byte(8'h33, 1'b1, "R8");
    recv_byte(8'h3C, 1'b1, "R8");
    recv_byte(8'h33, 1'b1, "R8");
    recv_byte(8'h3C, 1'b1, "R8");
    recv_byte(8'h71, 1'b1, "R8");
    recv_byte(8'h99, 1'b1, "R8");
    recv_byte(8'h99, 1'b1, "R9");
    recv_byte(8'h99, 1'b0, "R9");
    check_out(int'(sda_pull), 0, "R9", "SDA released after master NACK");
    bus_stop();
    check_out(int'(sda_pull), 0, "R10", "SDA released after stop");

    // R10 stop in mid-byte, then recovery
    bus_start();
    send_byte(DEV_W, 0, "R1");
    send_byte(8'h09, 0, "R3");
    partial_bits(4, 8'hF0);
    bus_stop();
    check_out(ctl_b, 'h3C, "R10", "ctl_b after stop mid-byte");
    bus_start();
    send_byte(DEV_W, 0, "R10");
    send_byte(8'h09, 0, "R3");
    send_byte(8'h5A, 0, "R3");
    bus_stop();
    check_out(ctl_b, 'h5A, "R3", "ctl_b after fresh write");

    // R10 start in mid-byte
    bus_start();
    send_byte(DEV_W, 0, "R1");
    send_byte(8'h11, 0, "R3");
    partial_bits(3, 8'hFF);
    bus_start();
    send_byte(DEV_W, 0, "R10");
    send_byte(8'h22, 0, "R3");
    send_byte(8'h0F, 0, "R3");
    bus_stop();
    check_out(ctl_c, 'h71, "R10", "ctl_c after start mid-byte");
    check_out(ctl_d, 'h0F, "R3", "ctl_d after restarted write");

    wait_n(10);
    if (exp_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: %0d expectations never observed", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule